// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block sits behind a fixed host memory window that is spread across several downstream host-bridge ports. Each incoming access carries an address measured from the start of the window, a read/write flag, a byte count and write data. The router adds the window's base to obtain the absolute host physical address. It splits that address into granules of a configured size and deals the granules round-robin across the configured number of ports. The absolute address and the chosen port are registered together with the rest of the request, and the request is then offered downstream.

When no usable port exists, the router answers the access itself. This covers a bad configuration, an offset past the window, an illegal byte count, or a selected port that is marked absent. A read that cannot be routed gets all-zero data with an error (poison) flag. A write that cannot be routed is dropped and completes with a clean response. The configuration inputs are static values from the surrounding system: base, size, port count, an optional granularity code, and a per-port presence mask.

Top module: `ilvr_window_router`

## Requirements
- R1: A forwarded request carries `fwdAddr` equal to `cfgBase + reqAddr`, wrapped to ADDR_W bits, and never the window-relative offset.
- R2: The port chosen is `(fwdAddr / G) mod cfgTargets`, where G = 256 << code. The code is `cfgGranCode` when `cfgGranValid` is 1 and is 0 (256-byte granules) when `cfgGranValid` is 0, whatever `cfgGranCode` holds.
- R3: `cfgError` is 1 whenever `cfgSize` is zero or its low 28 bits are not all zero, meaning the size is not a whole number of 256 MiB units.
- R4: `cfgError` is 1 when `cfgGranValid` is 1 with a code above 6, or when `cfgTargets` is 0 or exceeds NUM_PORTS. While `cfgError` is 1, every accepted request is answered locally.
- R5: An accepted read that cannot be routed produces `rspValid` for exactly one cycle with `rspErr` = 1 and `rspRdata` = 0, and nothing is forwarded.
- R6: An accepted write that cannot be routed produces `rspValid` for one cycle with `rspErr` = 0, and nothing is forwarded.
- R7: If the selected port's bit in `portPresent` (bit i for port i) is 0, the request is unroutable. A forwarded request always names a present port.
- R8: A request is unroutable when `reqAddr >= cfgSize` or when `reqSize` is outside 1..8. Unaligned addresses are legal. `fwdSize` and `fwdWdata` carry the request's byte count and little-endian data unchanged.
- R9: `reqReady` is 1 only while no result is pending. The result of an accepted request appears the cycle after acceptance as exactly one of `fwdValid` or `rspValid`. `fwdValid` and its fields hold steady until `fwdReady` is sampled 1.
- R10: After reset, `reqReady` is 1 and both `fwdValid` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | ADDR_W | Absolute base address of the window |
| cfgSize | input | ADDR_W | Window size in bytes |
| cfgTargets | input | CNT_W | Number of interleaved ports |
| cfgGranValid | input | 1 | 1 when a granularity code is supplied |
| cfgGranCode | input | GC_W | Granularity code, granule = 256 << code |
| portPresent | input | NUM_PORTS | Presence bit per downstream port |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted this cycle when valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Window-relative byte address |
| reqSize | input | SZ_W | Access size in bytes |
| reqWdata | input | DATA_W | Write data, little-endian |
| fwdValid | output | 1 | Routed request offered downstream |
| fwdReady | input | 1 | Downstream takes the routed request |
| fwdWrite | output | 1 | Routed request is a write |
| fwdPort | output | PORT_W | Selected downstream port |
| fwdAddr | output | ADDR_W | Absolute host physical address |
| fwdSize | output | SZ_W | Access size in bytes |
| fwdWdata | output | DATA_W | Write data |
| rspValid | output | 1 | Local completion for an unroutable request |
| rspErr | output | 1 | Poison flag on a local read completion |
| rspRdata | output | DATA_W | Read data on a local completion (zero) |
| cfgError | output | 1 | Configuration is invalid |

## Verification
A corrupted pending state shows up on the very next cycle. It appears as a stuck-low `reqReady`, a result on both channels at once, or a `fwdValid` that drops or changes its fields before `fwdReady`. A wrong routing decision made at acceptance is visible one cycle later as the wrong channel, port, address or poison flag. Because the bench compares every output on every cycle against a behavioural model, such a fault is caught within the cycle it first appears, not at the end of a transaction.

// File: rtl/ilvr_pkg.sv
package ilvr_pkg;

  // Granule of code 0 is 2**GRAN_BASE_SHIFT bytes.
  localparam int GRAN_BASE_SHIFT  = 8;
  // Window size must be a multiple of 2**WIN_ALIGN_BITS bytes.
  localparam int WIN_ALIGN_BITS   = 28;
  localparam int MAX_GRAN_CODE    = 6;
  localparam int MAX_ACCESS_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RSP  = 2'd2
  } ilvrState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // request accepted this cycle
    logic localRsp;  // accepted request will be answered locally
  } ilvrStrobe_t;

endpackage

// File: rtl/ilvr_cfg_check.sv
module ilvr_cfg_check
  import ilvr_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_PORTS = 8,
  parameter int CNT_W     = 4,
  parameter int GC_W      = 4
) (
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [CNT_W-1:0]  cfgTargets,
  input  logic              cfgGranValid,
  input  logic [GC_W-1:0]   cfgGranCode,
  output logic              cfgError,
  output logic [GC_W-1:0]   effCode
);

  logic sizeBad;
  logic granBad;
  logic countBad;

  always_comb begin
    sizeBad  = (cfgSize[WIN_ALIGN_BITS-1:0] != '0) || (cfgSize == '0);
    granBad  = cfgGranValid && (cfgGranCode > GC_W'(MAX_GRAN_CODE));
    countBad = (cfgTargets == '0) || (cfgTargets > CNT_W'(NUM_PORTS));
    cfgError = sizeBad || granBad || countBad;
    effCode  = cfgGranValid ? cfgGranCode : '0;
  end

endmodule

// File: rtl/ilvr_datapath.sv
module ilvr_datapath
  import ilvr_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 64,
  parameter int NUM_PORTS = 8,
  parameter int CNT_W     = 4,
  parameter int PORT_W    = 3,
  parameter int GC_W      = 4,
  parameter int SZ_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ilvrStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    cfgBase,
  input  logic [ADDR_W-1:0]    cfgSize,
  input  logic [CNT_W-1:0]     cfgTargets,
  input  logic [GC_W-1:0]      effCode,
  input  logic                 cfgError,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [SZ_W-1:0]      reqSize,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 routeOk,
  output logic                 fwdWrite,
  output logic [PORT_W-1:0]    fwdPort,
  output logic [ADDR_W-1:0]    fwdAddr,
  output logic [SZ_W-1:0]      fwdSize,
  output logic [DATA_W-1:0]    fwdWdata,
  output logic                 errFlag,
  output logic [DATA_W-1:0]    rspRdata
);

  localparam int SHIFT_W = GC_W + 4;

  logic [ADDR_W-1:0]    absAddr;
  logic [ADDR_W-1:0]    chunk;
  logic [ADDR_W-1:0]    divisor;
  logic [ADDR_W-1:0]    remainder;
  logic [CNT_W-1:0]     tgtIdx;
  logic [NUM_PORTS-1:0] hitVec;
  logic                 portHit;
  logic                 inWindow;
  logic                 sizeOk;

  always_comb begin
    absAddr   = cfgBase + reqAddr;
    chunk     = absAddr >> (SHIFT_W'(GRAN_BASE_SHIFT) + SHIFT_W'(effCode));
    divisor   = (cfgTargets == '0) ? ADDR_W'(1) : ADDR_W'(cfgTargets);
    remainder = chunk % divisor;
    tgtIdx    = remainder[CNT_W-1:0];
  end

  // One comparator per port: selected and present.
  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_hit
    assign hitVec[gi] = (tgtIdx == CNT_W'(gi)) && portPresent[gi];
  end

  always_comb begin
    portHit  = |hitVec;
    inWindow = reqAddr < cfgSize;
    sizeOk   = (reqSize != '0) && (reqSize <= SZ_W'(MAX_ACCESS_BYTES));
    routeOk  = !cfgError && inWindow && sizeOk && portHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdWrite <= 1'b0;
      fwdPort  <= '0;
      fwdAddr  <= '0;
      fwdSize  <= '0;
      fwdWdata <= '0;
      errFlag  <= 1'b0;
    end else if (strobe.capture) begin
      fwdWrite <= reqWrite;
      fwdPort  <= tgtIdx[PORT_W-1:0];
      fwdAddr  <= absAddr;
      fwdSize  <= reqSize;
      fwdWdata <= reqWdata;
      errFlag  <= strobe.localRsp && !reqWrite;
    end
  end

  // Local completions never carry data.
  assign rspRdata = '0;

endmodule

// File: rtl/ilvr_ctrl.sv
module ilvr_ctrl
  import ilvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        fwdReady,
  input  logic        routeOk,
  output logic        reqReady,
  output logic        fwdValid,
  output logic        rspValid,
  output ilvrStrobe_t strobe
);

  ilvrState_e state;
  ilvrState_e stateNext;
  logic       accept;

  always_comb begin
    reqReady        = (state == ST_IDLE);
    accept          = reqValid && reqReady;
    strobe.capture  = accept;
    strobe.localRsp = accept && !routeOk;
    stateNext       = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = routeOk ? ST_FWD : ST_RSP;
      ST_FWD:  if (fwdReady) stateNext = ST_IDLE;
      ST_RSP:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign fwdValid = (state == ST_FWD);
  assign rspValid = (state == ST_RSP);

endmodule

// File: rtl/ilvr_window_router.sv
module ilvr_window_router
  import ilvr_pkg::*;
#(
  parameter int  ADDR_W    = 40,
  parameter int  DATA_W    = 64,
  parameter int  NUM_PORTS = 8,
  parameter int  GC_W      = 4,
  parameter int  SZ_W      = 4,
  localparam int CNT_W     = $clog2(NUM_PORTS + 1),
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cfgBase,
  input  logic [ADDR_W-1:0]    cfgSize,
  input  logic [CNT_W-1:0]     cfgTargets,
  input  logic                 cfgGranValid,
  input  logic [GC_W-1:0]      cfgGranCode,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [SZ_W-1:0]      reqSize,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 fwdValid,
  input  logic                 fwdReady,
  output logic                 fwdWrite,
  output logic [PORT_W-1:0]    fwdPort,
  output logic [ADDR_W-1:0]    fwdAddr,
  output logic [SZ_W-1:0]      fwdSize,
  output logic [DATA_W-1:0]    fwdWdata,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 cfgError
);

  ilvrStrobe_t     strobe;
  logic            routeOk;
  logic            errFlag;
  logic [GC_W-1:0] effCode;

  ilvr_cfg_check #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .GC_W(GC_W)
  ) u_cfg (
    .cfgSize(cfgSize), .cfgTargets(cfgTargets), .cfgGranValid(cfgGranValid),
    .cfgGranCode(cfgGranCode), .cfgError(cfgError), .effCode(effCode)
  );

  ilvr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fwdReady(fwdReady),
    .routeOk(routeOk), .reqReady(reqReady), .fwdValid(fwdValid),
    .rspValid(rspValid), .strobe(strobe)
  );

  ilvr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W),
    .PORT_W(PORT_W), .GC_W(GC_W), .SZ_W(SZ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase),
    .cfgSize(cfgSize), .cfgTargets(cfgTargets), .effCode(effCode),
    .cfgError(cfgError), .portPresent(portPresent), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .routeOk(routeOk), .fwdWrite(fwdWrite), .fwdPort(fwdPort),
    .fwdAddr(fwdAddr), .fwdSize(fwdSize), .fwdWdata(fwdWdata),
    .errFlag(errFlag), .rspRdata(rspRdata)
  );

  assign rspErr = rspValid && errFlag;

endmodule

// File: rtl/ilvr_checker.sv
module ilvr_checker #(
  parameter int ADDR_W    = 40,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 fwdValid,
  input logic                 fwdReady,
  input logic [ADDR_W-1:0]    fwdAddr,
  input logic [PORT_W-1:0]    fwdPort,
  input logic [NUM_PORTS-1:0] portPresent,
  input logic                 rspValid,
  input logic                 rspErr,
  input logic                 cfgError
);

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid || rspValid) |-> !reqReady);

  // R9
  accept_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (fwdValid != rspValid));

  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> (fwdValid && $stable(fwdAddr) && $stable(fwdPort)));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5
  err_only_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  // R7
  port_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdValid) |-> portPresent[fwdPort]);

  // R4
  cfg_err_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && cfgError) |=> rspValid);

endmodule

bind ilvr_window_router ilvr_checker #(
  .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdAddr(fwdAddr),
  .fwdPort(fwdPort), .portPresent(portPresent), .rspValid(rspValid),
  .rspErr(rspErr), .cfgError(cfgError)
);

// File: tb/ilvr_window_router_bench.sv
module ilvr_window_router_bench;

  localparam int AW = 40;
  localparam int DW = 64;
  localparam int NP = 8;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int GW = 4;
  localparam int SW = 4;
  localparam longint unsigned AMASK = (64'd1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] cfgBase = '0;
  logic [AW-1:0] cfgSize = '0;
  logic [CW-1:0] cfgTargets = '0;
  logic          cfgGranValid = 1'b0;
  logic [GW-1:0] cfgGranCode = '0;
  logic [NP-1:0] portPresent = '0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [SW-1:0] reqSize = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          fwdValid;
  logic          fwdReady = 1'b0;
  logic          fwdWrite;
  logic [PW-1:0] fwdPort;
  logic [AW-1:0] fwdAddr;
  logic [SW-1:0] fwdSize;
  logic [DW-1:0] fwdWdata;
  logic          rspValid;
  logic          rspErr;
  logic [DW-1:0] rspRdata;
  logic          cfgError;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ilvr_window_router u_ilvr_window_router (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgTargets(cfgTargets), .cfgGranValid(cfgGranValid),
    .cfgGranCode(cfgGranCode), .portPresent(portPresent),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdWrite(fwdWrite),
    .fwdPort(fwdPort), .fwdAddr(fwdAddr), .fwdSize(fwdSize),
    .fwdWdata(fwdWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .cfgError(cfgError)
  );

  // ---------------- reference model ----------------
  bit              mFwd = 0;
  bit              mRsp = 0;
  longint unsigned mAddr = 0;
  int              mPort = 0;
  bit              mWrite = 0;
  int              mSize = 0;
  logic [DW-1:0]   mWdata = '0;
  bit              mErr = 0;
  string           mWhy = "R9";
  string           mRspTag = "R5";

  function automatic bit sizeBadM();
    return (cfgSize == 0) || ((longint'(cfgSize) % (64'd1 << 28)) != 0);
  endfunction

  function automatic bit cfgErrM();
    return sizeBadM() || (cfgGranValid && cfgGranCode > 6) ||
           (cfgTargets == 0) || (int'(cfgTargets) > NP);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFwd = 0;
      mRsp = 0;
    end else begin
      bit wasIdle;
      wasIdle = !mFwd && !mRsp;
      if (mFwd && fwdReady) mFwd = 0;
      if (mRsp) mRsp = 0;
      if (wasIdle && reqValid) begin
        longint unsigned absA;
        longint unsigned gran;
        int code;
        int port;
        bit ok;
        absA  = (longint'(cfgBase) + longint'(reqAddr)) & AMASK;
        code  = cfgGranValid ? int'(cfgGranCode) : 0;
        ok    = 1;
        port  = 0;
        if (cfgErrM()) begin
          ok = 0; mWhy = "R4";
        end else if (longint'(reqAddr) >= longint'(cfgSize) ||
                     reqSize == 0 || reqSize > 8) begin
          ok = 0; mWhy = "R8";
        end else begin
          gran = 64'd256 << code;
          port = int'((absA / gran) % longint'(cfgTargets));
          if (!portPresent[port]) begin
            ok = 0; mWhy = "R7";
          end else mWhy = "R2";
        end
        if (ok) begin
          mFwd = 1; mAddr = absA; mPort = port; mWrite = reqWrite;
          mSize = int'(reqSize); mWdata = reqWdata;
        end else begin
          mRsp = 1; mErr = !reqWrite;
          mRspTag = reqWrite ? "R6" : "R5";
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkCycle();
    chk("R9", "reqReady", 64'(reqReady), 64'(!mFwd && !mRsp));
    chk(mWhy, "fwdValid", 64'(fwdValid), 64'(mFwd));
    chk(mWhy, "rspValid", 64'(rspValid), 64'(mRsp));
    chk(sizeBadM() ? "R3" : "R4", "cfgError", 64'(cfgError), 64'(cfgErrM()));
    if (mFwd && fwdValid) begin
      chk("R1", "fwdAddr", 64'(fwdAddr), mAddr);
      chk("R2", "fwdPort", 64'(fwdPort), 64'(mPort));
      chk("R8", "fwdSize", 64'(fwdSize), 64'(mSize));
      chk("R8", "fwdWdata", fwdWdata, mWdata);
      chk("R9", "fwdWrite", 64'(fwdWrite), 64'(mWrite));
    end
    if (mRsp && rspValid) begin
      chk(mRspTag, "rspErr", 64'(rspErr), 64'(mErr));
      chk("R5", "rspRdata", rspRdata, 64'd0);
    end
  endtask

  task automatic runPhase(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      longint unsigned r;
      @(negedge clk);
      checkCycle();
      r        = {$urandom, $urandom};
      reqValid = ($urandom % 4) != 0;
      reqWrite = $urandom % 2;
      if ($urandom % 8 == 0 || cfgSize == 0)
        reqAddr = AW'(longint'(cfgSize) + (r % 4096));
      else
        reqAddr = AW'(r % longint'(cfgSize));
      reqSize  = ($urandom % 10 == 0) ? SW'(($urandom % 2) ? 0 : 9 + $urandom % 7)
                                      : SW'(1 + $urandom % 8);
      reqWdata = {$urandom, $urandom};
      fwdReady = ($urandom % 3) != 0;
    end
  endtask

  task automatic quiesce();
    reqValid = 0;
    fwdReady = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkCycle();
    end
  endtask

  task automatic setCfg(input logic [AW-1:0] b, input logic [AW-1:0] s,
                        input int t, input bit gv, input int gc,
                        input logic [NP-1:0] pp);
    quiesce();
    cfgBase = b; cfgSize = s; cfgTargets = CW'(t);
    cfgGranValid = gv; cfgGranCode = GW'(gc); portPresent = pp;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    cfgBase = 40'h01_0000_0000; cfgSize = 40'h00_2000_0000;
    cfgTargets = 4; cfgGranValid = 0; cfgGranCode = 0; portPresent = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: state right after reset
    chk("R10", "reqReady", 64'(reqReady), 64'd1);
    chk("R10", "fwdValid", 64'(fwdValid), 64'd0);
    chk("R10", "rspValid", 64'(rspValid), 64'd0);

    runPhase(400);                                             // 4 ports, default granule
    setCfg(40'h00_3000_0000, 40'h00_3000_0000, 3, 1, 2, 8'hFD); // port 1 absent, R7
    runPhase(400);
    setCfg(40'h00_0000_0000, 40'h00_4000_0000, 6, 1, 6, 8'hDF); // 16 KiB granule
    runPhase(400);
    setCfg(40'hFF_F000_0000, 40'h00_2000_0000, 8, 1, 1, 8'hFF); // base wraps, R1
    runPhase(400);
    setCfg(40'h00_1000_0000, 40'h00_1000_0000, 5, 1, 3, 8'h1F);
    runPhase(300);
    setCfg(40'h00_1000_0000, 40'h00_1000_0000, 1, 0, 9, 8'h01); // code ignored, R2
    runPhase(200);
    setCfg(40'h00_1000_0000, 40'h00_1000_0100, 4, 0, 0, 8'hFF); // R3 misaligned size
    runPhase(100);
    setCfg(40'h00_1000_0000, 40'h00_0000_0000, 4, 0, 0, 8'hFF); // R3 zero size
    runPhase(100);
    setCfg(40'h00_1000_0000, 40'h00_1000_0000, 4, 1, 7, 8'hFF); // R4 bad code
    runPhase(100);
    setCfg(40'h00_1000_0000, 40'h00_1000_0000, 0, 0, 0, 8'hFF); // R4 zero ports
    runPhase(100);
    setCfg(40'h00_1000_0000, 40'h00_1000_0000, 9, 0, 0, 8'hFF); // R4 too many ports
    runPhase(100);
    setCfg(40'h02_0000_0000, 40'h00_1000_0000, 2, 0, 0, 8'h03);
    runPhase(200);
    quiesce();
    finishRun();
  end

endmodule